// File: doc/BRIEF.md
# CAN Controller Operating-Mode Sequencer

This block is the mode-control state machine of a CAN controller. It keeps the controller in one of three software-visible modes: sleep, initialization, or normal operation. Normal operation has an internal bus-synchronization phase that comes before it. Software drives an initialization request level and writes a sleep bit. It then polls the initialization and sleep acknowledge outputs to learn when a mode change has taken effect. Software also sets the auto-wake-up enable and the wake-up interrupt enable.

The receive line passes through a synchronizer. While the block is synchronizing, it samples that line once per bit time, using a strobe supplied by the bit-timing logic. The block joins bus traffic only after it has seen 11 consecutive recessive bits. In sleep, any dominant level on the receive line counts as bus activity. Bus activity can raise a sticky wake-up interrupt, and it can also clear the sleep bit in hardware when auto wake-up is enabled. Outside normal mode the block holds the transmit path recessive. Its `on_bus` output is the enable that gates the frame, mailbox and filter logic.

Top module: `can_mode_seq`

## Requirements
- R1: After reset the block is in sleep: `sleep_bit`=1, `sleep_ack`=1, `init_ack`=0, `on_bus`=0, `tx_force_rec`=1, `wake_irq`=0.
- R2: Outside sleep, holding `init_req`=1 puts the block in initialization within one cycle. In that mode `init_ack`=1, `on_bus`=0 and `tx_force_rec`=1.
- R3: While the block is in sleep, `init_req`=1 is not acknowledged and `init_ack` stays 0.
- R4: When `init_req` is cleared with the sleep bit clear, `init_ack` drops to 0. `on_bus` rises only after 11 consecutive `bit_tick` samples of a recessive (1) receive line.
- R5: A dominant (0) sample during the idle search restarts the count, so 11 further recessive samples are needed.
- R6: `on_bus`=1 only in normal mode. Whenever `init_ack` or `sleep_ack` is 1, `on_bus`=0 and `tx_force_rec`=1.
- R7: Writing 1 to the sleep bit moves the block from normal or synchronizing to sleep. The same write from initialization takes effect only once `init_req` is cleared, because `init_req` has priority.
- R8: Clearing the sleep bit by a write leaves sleep. The block goes to initialization if `init_req`=1 and to bus synchronization otherwise.
- R9: A dominant receive level in sleep with `auto_wake_en`=1 clears `sleep_bit` in hardware and leaves sleep. With `auto_wake_en`=0 the sleep bit and the mode are unchanged.
- R10: A dominant receive level in sleep sets `wake_irq` when `wake_ie`=1, including during an automatic wake-up. With `wake_ie`=0 it does not.
- R11: A pulse on `wake_clr` clears `wake_irq` (write-one-to-clear). If a new wake event occurs in the same cycle, the set wins.
- R12: A software write to the sleep bit wins over a hardware auto-wake clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle strobe at each bit sample point |
| can_rx | input | 1 | Asynchronous receive line (1 = recessive) |
| init_req | input | 1 | Initialization request level from software |
| sleep_wr | input | 1 | Write strobe for the sleep bit |
| sleep_wdata | input | 1 | Value written to the sleep bit |
| auto_wake_en | input | 1 | Hardware clears the sleep bit on bus activity |
| wake_ie | input | 1 | Wake-up interrupt enable |
| wake_clr | input | 1 | Write-one-to-clear strobe for the wake-up flag |
| sleep_bit | output | 1 | Current value of the sleep bit |
| init_ack | output | 1 | Initialization mode acknowledged |
| sleep_ack | output | 1 | Sleep mode acknowledged |
| on_bus | output | 1 | Participating in bus traffic; gates transfer logic |
| tx_force_rec | output | 1 | Forces the transmit pin recessive |
| wake_irq | output | 1 | Wake-up interrupt pending |

## Verification
Two kinds of update can land in the same cycle: a bus-activity event in sleep and a software access. This happens when the wake flag is cleared while activity is still present, and when the sleep bit is written while auto wake-up would clear it. The bench holds the receive line dominant long enough for the activity to pass the synchronizer. It then pulses `wake_clr`, or holds a sleep-bit write across the whole activity window. It expects the wake flag to remain set and the sleep bit to remain 1. The idle search is also probed at its boundary: 10 recessive bits, a dominant bit, then 10 and 11 recessive bits.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

    typedef enum logic [1:0] {
        MODE_SLEEP  = 2'd0,
        MODE_INIT   = 2'd1,
        MODE_SYNC   = 2'd2,
        MODE_NORMAL = 2'd3
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  sleep_bit;
        logic  wake_pend;
    } ctl_s;

endpackage

// File: rtl/can_rx_sync.sv
module can_rx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/can_idle_cnt.sv
module can_idle_cnt #(
    parameter int IDLE_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  logic rx,
    output logic idle
);
    localparam int            CW    = $clog2(IDLE_BITS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(IDLE_BITS);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (tick) begin
            if (!rx)                 cnt_d = '0;
            else if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign idle = (cnt_q == LIMIT);
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
    import can_mode_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int IDLE_BITS   = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic can_rx,
    input  logic init_req,
    input  logic sleep_wr,
    input  logic sleep_wdata,
    input  logic auto_wake_en,
    input  logic wake_ie,
    input  logic wake_clr,
    output logic sleep_bit,
    output logic init_ack,
    output logic sleep_ack,
    output logic on_bus,
    output logic tx_force_rec,
    output logic wake_irq
);
    localparam ctl_s CTL_RST = '{mode: MODE_SLEEP, sleep_bit: 1'b1, wake_pend: 1'b0};

    ctl_s ctl_d, ctl_q;
    logic rx_s;
    logic idle_seen;
    logic bus_act;

    can_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (can_rx),
        .dout  (rx_s)
    );

    can_idle_cnt #(.IDLE_BITS(IDLE_BITS)) u_idle (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctl_q.mode == MODE_SYNC),
        .tick  (bit_tick),
        .rx    (rx_s),
        .idle  (idle_seen)
    );

    always_comb begin
        ctl_d   = ctl_q;
        bus_act = (ctl_q.mode == MODE_SLEEP) && !rx_s;

        // sleep bit: software write outranks hardware wake clear
        if (sleep_wr)                     ctl_d.sleep_bit = sleep_wdata;
        else if (bus_act && auto_wake_en) ctl_d.sleep_bit = 1'b0;

        // wake flag: set outranks write-one-to-clear
        if (wake_clr)           ctl_d.wake_pend = 1'b0;
        if (bus_act && wake_ie) ctl_d.wake_pend = 1'b1;

        unique case (ctl_q.mode)
            MODE_SLEEP: begin
                if (!ctl_q.sleep_bit)
                    ctl_d.mode = init_req ? MODE_INIT : MODE_SYNC;
            end
            MODE_INIT: begin
                if (!init_req)
                    ctl_d.mode = ctl_q.sleep_bit ? MODE_SLEEP : MODE_SYNC;
            end
            default: begin
                if (init_req)                                  ctl_d.mode = MODE_INIT;
                else if (ctl_q.sleep_bit)                      ctl_d.mode = MODE_SLEEP;
                else if (ctl_q.mode == MODE_SYNC && idle_seen) ctl_d.mode = MODE_NORMAL;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign sleep_bit    = ctl_q.sleep_bit;
    assign init_ack     = (ctl_q.mode == MODE_INIT);
    assign sleep_ack    = (ctl_q.mode == MODE_SLEEP);
    assign on_bus       = (ctl_q.mode == MODE_NORMAL);
    assign tx_force_rec = !on_bus;
    assign wake_irq     = ctl_q.wake_pend;
endmodule

// File: rtl/can_mode_seq_chk.sv
module can_mode_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic init_req,
    input logic sleep_wr,
    input logic auto_wake_en,
    input logic wake_ie,
    input logic wake_clr,
    input logic sleep_bit,
    input logic init_ack,
    input logic sleep_ack,
    input logic on_bus,
    input logic tx_force_rec,
    input logic wake_irq
);
    AST_INIT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (init_req && !sleep_ack) |=> init_ack); // R2
    AST_SLEEP_NO_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_ack |-> !init_ack); // R3
    AST_JOIN_FROM_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(on_bus) |-> ($past(!init_ack) && $past(!sleep_ack))); // R4
    AST_TX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (init_ack || sleep_ack) |-> (tx_force_rec && !on_bus)); // R6
    AST_NO_SELF_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_ack && sleep_bit && !auto_wake_en && !sleep_wr) |=> sleep_bit); // R9
    AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_irq) |-> $past(wake_ie)); // R10
    AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_clr && !sleep_ack) |=> !wake_irq); // R11
endmodule

bind can_mode_seq can_mode_seq_chk u_chk (.*);

// File: tb/tb_can_mode_seq.sv
module tb_can_mode_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b0, can_rx = 1'b1, init_req = 1'b0;
    logic sleep_wr = 1'b0, sleep_wdata = 1'b0, auto_wake_en = 1'b0;
    logic wake_ie = 1'b0, wake_clr = 1'b0;
    logic sleep_bit, init_ack, sleep_ack, on_bus, tx_force_rec, wake_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    can_mode_seq dut (.*);

    // init_req, sleep_wr, sleep_wdata, ticks[3:0] | exp init_ack, sleep_ack, on_bus, sleep_bit
    localparam int NV = 10;
    localparam logic [10:0] VEC [NV] = '{
        11'b1_0_0_0000_0101,
        11'b1_1_0_0000_1000,
        11'b0_0_0_1010_0000,
        11'b0_0_0_0001_0010,
        11'b1_0_0_0000_1000,
        11'b1_1_1_0000_1001,
        11'b0_0_0_0000_0101,
        11'b0_1_0_0000_0000,
        11'b0_0_0_1011_0010,
        11'b0_1_1_0000_0101
    };

    function automatic string vtag(int i);
        case (i)
            0:       return "R3";
            1, 7:    return "R8";
            4:       return "R2";
            5, 6, 9: return "R7";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(string tag, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick(logic lvl);
        can_rx = lvl;
        cyc(3);
        bit_tick = 1'b1;
        cyc(1);
        bit_tick = 1'b0;
        can_rx = 1'b1;
        cyc(3);
    endtask

    task automatic wr_sleep(logic v);
        sleep_wr = 1'b1; sleep_wdata = v;
        cyc(1);
        sleep_wr = 1'b0;
    endtask

    task automatic mode_chk(string tag, logic ia, logic sa, logic ob, logic sb);
        chk(tag, "init_ack", init_ack, ia);
        chk(tag, "sleep_ack", sleep_ack, sa);
        chk(tag, "on_bus", on_bus, ob);
        chk(tag, "sleep_bit", sleep_bit, sb);
    endtask

    initial begin
        cyc(2000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual expired expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        // R1 reset state
        mode_chk("R1", 1'b0, 1'b1, 1'b0, 1'b1);
        chk("R1", "tx_force_rec", tx_force_rec, 1'b1);
        chk("R1", "wake_irq", wake_irq, 1'b0);

        for (int i = 0; i < NV; i++) begin
            init_req = VEC[i][10];
            if (VEC[i][9]) wr_sleep(VEC[i][8]);
            cyc(3);
            for (int t = 0; t < int'(VEC[i][7:4]); t++) tick(1'b1);
            cyc(4);
            mode_chk(vtag(i), VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);
            chk("R6", "tx_force_rec", tx_force_rec, !VEC[i][1]);
        end

        // R5: dominant bit restarts the idle search
        wr_sleep(1'b0);
        cyc(3);
        for (int t = 0; t < 10; t++) tick(1'b1);
        tick(1'b0);
        for (int t = 0; t < 10; t++) tick(1'b1);
        cyc(3);
        chk("R5", "on_bus after 10 post-dominant", on_bus, 1'b0);
        tick(1'b1);
        cyc(3);
        chk("R5", "on_bus after 11 post-dominant", on_bus, 1'b1);

        // R9 / R10: activity without auto wake, interrupt enabled
        wr_sleep(1'b1);
        cyc(3);
        wake_ie = 1'b1;
        can_rx = 1'b0; cyc(5); can_rx = 1'b1; cyc(5);
        chk("R9", "sleep_bit kept", sleep_bit, 1'b1);
        chk("R9", "sleep_ack kept", sleep_ack, 1'b1);
        chk("R10", "wake_irq set", wake_irq, 1'b1);

        // R11: write-one-to-clear
        wake_clr = 1'b1; cyc(1); wake_clr = 1'b0; cyc(1);
        chk("R11", "wake_irq cleared", wake_irq, 1'b0);

        // R11: clear collides with a new wake event, set wins
        can_rx = 1'b0; cyc(4);
        wake_clr = 1'b1; cyc(1); wake_clr = 1'b0;
        chk("R11", "set wins over clear", wake_irq, 1'b1);
        can_rx = 1'b1; cyc(4);

        // R10: interrupt disabled
        wake_clr = 1'b1; cyc(1); wake_clr = 1'b0;
        wake_ie = 1'b0;
        can_rx = 1'b0; cyc(5); can_rx = 1'b1; cyc(5);
        chk("R10", "wake_irq with ie=0", wake_irq, 1'b0);

        // R12: software write held across activity with auto wake on
        auto_wake_en = 1'b1;
        sleep_wr = 1'b1; sleep_wdata = 1'b1;
        can_rx = 1'b0; cyc(5); can_rx = 1'b1; cyc(4);
        sleep_wr = 1'b0; cyc(2);
        chk("R12", "sleep_bit kept by write", sleep_bit, 1'b1);
        chk("R12", "sleep_ack kept", sleep_ack, 1'b1);

        // R9 / R10: automatic wake-up with interrupt
        wake_ie = 1'b1;
        can_rx = 1'b0; cyc(4); can_rx = 1'b1; cyc(5);
        chk("R9", "sleep_bit cleared by hw", sleep_bit, 1'b0);
        chk("R9", "sleep_ack dropped", sleep_ack, 1'b0);
        chk("R10", "wake_irq with auto wake", wake_irq, 1'b1);
        chk("R4", "not on bus before idle", on_bus, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule